// File: doc/BRIEF.md
# Dual-Mode Watchdog Reset Controller

This block watches a processor core for signs of life. The core must pulse a service strobe regularly; each pulse reloads a down-counter from a programmable timeout value. If the counter reaches zero and another cycle passes without a strobe, the watchdog expires and starts a recovery action.

The recovery action is chosen by a boot-mode pin that is captured while reset is held and frozen once reset is released. In standalone mode the block drives a chip-wide reset for a fixed number of cycles. It then pulses a reboot request so that a boot sequencer can reload code from external memory, and the watchdog starts counting again. In hosted mode the block raises a notification line to an external host and holds it until the host acknowledges. The counter is frozen while the notification is pending and is reloaded on the acknowledge.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after the last reset edge, `chip_rst`, `reboot_req` and `host_note` are all low.
- R2: With timeout value L and no strobe, expiry takes effect on the (L+1)-th rising clock edge after reset release, or after the last accepted strobe. The outputs change on that edge.
- R3: A strobe sampled on the same edge at which the counter is zero is in time: it reloads the counter and no expiry occurs. Strobing every L+1 edges therefore never expires.
- R4: The mode is the value of `mode_pin` at the last clock edge with `rst` high (1 = hosted, 0 = standalone). Changes of `mode_pin` after release have no effect.
- R5: In standalone mode an expiry drives `chip_rst` high for exactly 16 consecutive cycles.
- R6: `reboot_req` is high for exactly one cycle, the cycle right after `chip_rst` falls.
- R7: In standalone mode, the edge that ends `chip_rst` also reloads the counter, so the next expiry follows L+1 edges later if no strobe arrives.
- R8: In hosted mode an expiry sets `host_note`. It stays high, even when strobes arrive, until `host_ack` is sampled high. `chip_rst` never rises in hosted mode.
- R9: `host_ack` sampled high while `host_note` is set clears `host_note` on that edge and reloads the counter. `host_ack` while no notification is pending has no effect on the expiry timing.
- R10: In standalone mode `host_note` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; watchdog idle while high |
| mode_pin | input | 1 | Boot-mode select, captured during reset (1 = hosted) |
| svc_strobe | input | 1 | Service strobe from the core; reloads the counter |
| tmo_load | input | CNT_W | Timeout reload value L |
| host_ack | input | 1 | Host acknowledge of a pending notification |
| chip_rst | output | 1 | Chip-wide reset request (standalone recovery) |
| reboot_req | output | 1 | One-cycle request to reboot from external memory |
| host_note | output | 1 | Expiry notification to the host (hosted recovery) |

## Verification
The hardest situation to reach from the ports is a service strobe arriving on exactly the edge at which the counter sits at zero. One cycle earlier is an ordinary reload, and one cycle later is an expiry. The bench reaches this case by counting edges from reset release and strobing every L+1 edges. It then confirms that dropping one strobe produces an expiry on the predicted edge. A second case is the hosted acknowledge path. There the bench checks both that strobes are ignored during a pending notification and that the counter restarts exactly at the acknowledge edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_NOTE = 2'd2
  } wd_state_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             svc,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt <= load_val;
    end else if (en) begin
      if (svc) cnt <= load_val;
      else if (cnt != ZERO) cnt <= cnt - ONE;
    end
  end

  // a strobe on the zero edge wins over expiry
  assign expire = en && !svc && (cnt == ZERO);
endmodule

// File: rtl/wdog_recovery_fsm.sv
module wdog_recovery_fsm
  import wdog_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_hosted,
  input  logic expire,
  input  logic host_ack,
  output logic run,
  output logic reload,
  output logic chip_rst,
  output logic reboot_req,
  output logic host_note
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

  wd_state_t         state;
  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_done;

  assign hold_done = (state == ST_HOLD) && (hold_cnt == HOLD_LAST);
  assign run = (state == ST_RUN);
  assign reload = hold_done || ((state == ST_NOTE) && host_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      hold_cnt   <= '0;
      chip_rst   <= 1'b0;
      reboot_req <= 1'b0;
      host_note  <= 1'b0;
    end else begin
      reboot_req <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (expire) begin
            if (mode_hosted) begin
              host_note <= 1'b1;
              state     <= ST_NOTE;
            end else begin
              chip_rst <= 1'b1;
              hold_cnt <= '0;
              state    <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (hold_done) begin
            chip_rst   <= 1'b0;
            reboot_req <= 1'b1;
            state      <= ST_RUN;
          end else begin
            hold_cnt <= hold_cnt + HOLD_ONE;
          end
        end
        ST_NOTE: begin
          if (host_ack) begin
            host_note <= 1'b0;
            state     <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl #(
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pin,
  input  logic             svc_strobe,
  input  logic [CNT_W-1:0] tmo_load,
  input  logic             host_ack,
  output logic             chip_rst,
  output logic             reboot_req,
  output logic             host_note
);
  logic mode_q;
  logic run;
  logic reload;
  logic expire;

  // mode follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_pin;
  end

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (run),
    .svc      (svc_strobe),
    .reload   (reload),
    .load_val (tmo_load),
    .expire   (expire)
  );

  wdog_recovery_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mode_hosted (mode_q),
    .expire      (expire),
    .host_ack    (host_ack),
    .run         (run),
    .reload      (reload),
    .chip_rst    (chip_rst),
    .reboot_req  (reboot_req),
    .host_note   (host_note)
  );
endmodule

// File: rtl/wdog_rst_ctrl_chk.sv
module wdog_rst_ctrl_chk #(
  parameter int HOLD_CYC = 16
) (
  input logic clk,
  input logic rst,
  input logic mode_q,
  input logic host_ack,
  input logic chip_rst,
  input logic reboot_req,
  input logic host_note
);
  localparam int LEN_W = $clog2(HOLD_CYC + 2) + 1;
  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (chip_rst) run_len <= run_len + LEN_W'(1);
    else run_len <= '0;
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!chip_rst && !reboot_req && !host_note)); // R1
  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst) $fell(chip_rst) |-> (run_len == LEN_W'(HOLD_CYC))); // R5
  AST_HOLD_MAX: assert property (@(posedge clk) disable iff (rst) chip_rst |-> (run_len <= LEN_W'(HOLD_CYC))); // R5
  AST_BOOT_PULSE: assert property (@(posedge clk) disable iff (rst) reboot_req |=> !reboot_req); // R6
  AST_BOOT_AFTER: assert property (@(posedge clk) disable iff (rst) $rose(reboot_req) |-> ($past(chip_rst) && !chip_rst)); // R6
  AST_NOTE_HOLD: assert property (@(posedge clk) disable iff (rst) (host_note && !host_ack) |=> host_note); // R8
  AST_HOSTED_NO_RST: assert property (@(posedge clk) disable iff (rst) mode_q |-> !chip_rst); // R8
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst) (host_note && host_ack) |=> !host_note); // R9
  AST_ALONE_NO_NOTE: assert property (@(posedge clk) disable iff (rst) !mode_q |-> !host_note); // R10
endmodule

bind wdog_rst_ctrl wdog_rst_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_q     (mode_q),
  .host_ack   (host_ack),
  .chip_rst   (chip_rst),
  .reboot_req (reboot_req),
  .host_note  (host_note)
);

// File: tb/wdog_rst_ctrl_tb.sv
module wdog_rst_ctrl_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pin = 1'b0;
  logic svc_strobe = 1'b0;
  logic [CNT_W-1:0] tmo_load = '0;
  logic host_ack = 1'b0;
  logic chip_rst, reboot_req, host_note;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_rst_ctrl #(.CNT_W(CNT_W), .HOLD_CYC(16)) u_dut (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .svc_strobe(svc_strobe),
    .tmo_load(tmo_load), .host_ack(host_ack),
    .chip_rst(chip_rst), .reboot_req(reboot_req), .host_note(host_note)
  );

  // {mode, load[7:0], edges[7:0], exp chip_rst, exp reboot_req, exp host_note}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 8'd5, 8'd0,  3'b000},  // R1 right after release
    {1'b0, 8'd5, 8'd5,  3'b000},  // R2 one edge early
    {1'b0, 8'd5, 8'd6,  3'b100},  // R2 expiry edge
    {1'b0, 8'd5, 8'd21, 3'b100},  // R5 last held cycle
    {1'b0, 8'd5, 8'd22, 3'b010},  // R6 reboot pulse
    {1'b0, 8'd5, 8'd23, 3'b000},  // R6 pulse over
    {1'b1, 8'd5, 8'd5,  3'b000},  // R2 hosted early
    {1'b1, 8'd5, 8'd6,  3'b001},  // R8 note raised
    {1'b1, 8'd5, 8'd40, 3'b001},  // R8 note held
    {1'b1, 8'd3, 8'd4,  3'b001},  // R2 short timeout
    {1'b0, 8'd0, 8'd1,  3'b100},  // R2 zero timeout
    {1'b1, 8'd0, 8'd0,  3'b000}   // R1 zero timeout at release
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {rst,boot,note} actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic m, input int load);
    @(negedge clk);
    rst = 1'b1; mode_pin = m; tmo_load = CNT_W'(load);
    svc_strobe = 1'b0; host_ack = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  function automatic logic [2:0] outs();
    return {chip_rst, reboot_req, host_note};
  endfunction

  initial begin
    // R1 reset state while held
    @(negedge clk);
    rst = 1'b1;
    step(3);
    chk("R1", outs(), 3'b000);

    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][19], int'(VEC[v][18:11]));
      step(int'(VEC[v][10:3]));
      chk("R2/R5/R6/R8 table", outs(), VEC[v][2:0]);
    end

    // R3 strobe on the zero edge keeps the watchdog quiet
    do_reset(1'b0, 4);
    step(4);
    for (int k = 0; k < 10; k++) begin
      svc_strobe = 1'b1; step(1); svc_strobe = 1'b0;
      step(4);
      chk("R3 keepalive", outs(), 3'b000);
    end
    step(1);
    chk("R3 missed strobe expires", outs(), 3'b100);

    // R4 mode frozen after release
    do_reset(1'b0, 2);
    mode_pin = 1'b1;
    step(3);
    chk("R4 mode frozen", outs(), 3'b100);

    // R7 counter restarts after reboot
    do_reset(1'b0, 2);
    step(3);
    step(16);
    chk("R6 pulse", outs(), 3'b010);
    step(2);
    chk("R7 before second expiry", outs(), 3'b000);
    step(1);
    chk("R7 second expiry", outs(), 3'b100);

    // R8 strobes do not clear note; R9 ack clears and reloads
    do_reset(1'b1, 3);
    step(4);
    chk("R8 note", outs(), 3'b001);
    svc_strobe = 1'b1; step(1); svc_strobe = 1'b0;
    step(5);
    chk("R8 strobe ignored", outs(), 3'b001);
    host_ack = 1'b1; step(1); host_ack = 1'b0;
    chk("R9 ack clears", outs(), 3'b000);
    step(3);
    chk("R9 reload wait", outs(), 3'b000);
    step(1);
    chk("R9 reload expiry", outs(), 3'b001);

    // R9 ack without pending note has no effect
    do_reset(1'b1, 3);
    host_ack = 1'b1; step(1); host_ack = 1'b0;
    step(2);
    chk("R9 stray ack", outs(), 3'b000);
    step(1);
    chk("R9 stray ack timing", outs(), 3'b001);

    // R10 standalone long run never notifies
    do_reset(1'b0, 1);
    for (int k = 0; k < 40; k++) begin
      step(1);
      if (host_note !== 1'b0) chk("R10", outs(), 3'b000);
    end
    checks++;

    // R1 reset during hold clears chip_rst
    do_reset(1'b0, 1);
    step(4);
    rst = 1'b1; step(1);
    chk("R1 reset in hold", outs(), 3'b000);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule